// File: doc/BRIEF.md
# Prescaled Programmable Interval Timer

This block measures a programmable span of machine cycles for a small controller. A six-bit prescaler steps once on every cycle where the machine-cycle enable is high. It produces a tick once in every 63 such steps. A six-bit down-counter counts these ticks. When the down-counter would go below zero, the timer stops and raises a sticky done flag.

Software starts an interval by pulsing the load strobe with a six-bit value N. The done flag then rises after 63*(N+1) enabled cycles. Software polls the timer with the test strobe. That strobe produces a skip indication while the done flag is set. Only the next load clears the flag. A load issued while a count is still running discards that count and starts the new interval from the beginning.

Top module: `interval_timer`

## Requirements
- R1: After reset the timer is idle, `done` is 0, and `skip` is 0 even while `test` is 1.
- R2: A clock edge that samples `load` high stores `load_val` as the tick count, clears `done`, and restarts the prescaler. Enabled cycles are counted from the next edge onward.
- R3: Only edges that sample `cyc_en` high advance the timer. Edges with `cyc_en` low change neither the elapsed count nor `done`.
- R4: With `load_val` = N, `done` becomes 1 at the edge that samples the 63*(N+1)-th enabled cycle after the load. N=0 gives 63 cycles and N=63 gives 4032 cycles.
- R5: Once set, `done` stays 1 until a load. Further enabled cycles and test strobes do not clear it.
- R6: A load while a count is active drops the old count. The new interval is a full 63*(N+1) enabled cycles from that load.
- R7: `skip` is 1 in exactly those cycles where `test` is 1 and `done` is 1. It is a combinational result of the current flag.
- R8: If a load and the expiring tick fall on the same edge, the load wins, and `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle enable; one prescaler step per high edge |
| load | input | 1 | Start strobe; loads `load_val` and restarts |
| load_val | input | 6 | Tick count N for the interval |
| test | input | 1 | Poll strobe for the done flag |
| done | output | 1 | Sticky expiry flag |
| skip | output | 1 | Skip indication for the poll strobe |

## Verification
The assertions assume that every input is a known 0 or 1 at each sampling edge. They also assume that `load` is an ordinary synchronous strobe that may arrive at any time, including on the expiring edge. The bench drives all inputs at the falling edge from tasks, so nothing changes near a sampling edge. Random stimulus mixes the enable at varied duty cycles with loads at arbitrary moments. Directed cases cover the shortest interval, the longest interval, an abort in mid-count, and the load that collides with expiry.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int          CNT_W    = 6,
  parameter int          PRE_W    = 6,
  parameter logic [5:0]  PRE_TAPS = 6'b110000,
  parameter logic [5:0]  PRE_SEED = 6'b000001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             test,
  output logic             done,
  output logic             skip
);

  localparam int             PERIOD = (1 << PRE_W) - 1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [PRE_W-1:0] pre_next(input logic [PRE_W-1:0] s);
    pre_next = {s[PRE_W-2:0], ^(s & PRE_TAPS[PRE_W-1:0])};
  endfunction

  function automatic logic [PRE_W-1:0] pre_after(input logic [PRE_W-1:0] s, input int n);
    logic [PRE_W-1:0] v;
    v = s;
    for (int i = 0; i < n; i++) v = pre_next(v);
    pre_after = v;
  endfunction

  localparam logic [PRE_W-1:0] PRE_LAST = pre_after(PRE_SEED[PRE_W-1:0], PERIOD - 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             step, tick, borrow;

  assign step   = running & cyc_en;
  assign tick   = step & (pre == PRE_LAST);
  assign borrow = tick & (cnt == '0);
  assign skip   = test & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= PRE_SEED[PRE_W-1:0];
      cnt     <= '0;
      running <= 1'b0;
      done    <= 1'b0;
    end else if (load) begin
      pre     <= PRE_SEED[PRE_W-1:0];
      cnt     <= load_val;
      running <= 1'b1;
      done    <= 1'b0;
    end else if (step) begin
      pre <= pre_next(pre);
      if (borrow) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else if (tick) begin
        cnt <= cnt - ONE;
      end
    end
  end

  a_r2_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!done && running && pre == PRE_SEED[PRE_W-1:0]));

  a_r3_no_step_when_idle_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !load) |=> ($stable(pre) && $stable(cnt) && $stable(done)));

  a_r3_cnt_moves_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load) |=> (cnt == $past(cnt) || cnt == $past(cnt) - ONE));

  a_r4_done_only_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!running && cnt == '0 && $past(pre) == PRE_LAST));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

  a_r5_idle_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (!running && $stable(cnt) && $stable(pre)));

  a_r7_skip_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (done && test));

  a_r8_load_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (load && borrow) |=> !done);

endmodule

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0;
  logic       load = 1'b0;
  logic [5:0] load_val = '0;
  logic       test = 1'b0;
  logic       done, skip;

  int checks = 0;
  int fails  = 0;

  int  m_elapsed = 0;
  int  m_target  = 0;
  bit  m_active  = 0;
  bit  m_done    = 0;

  always #2 clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .load(load),
    .load_val(load_val), .test(test), .done(done), .skip(skip)
  );

  function automatic int interval_len(input int n);
    interval_len = 63 * (n + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit ld, input logic [5:0] v, input bit en, input bit ts, input string tag);
    bit pre_done;
    @(negedge clk);
    load = ld; load_val = v; cyc_en = en; test = ts;
    #1;
    chk(skip == (ts && m_done), "R7", int'(skip), int'(ts && m_done));
    pre_done = m_done;
    @(posedge clk);
    if (ld) begin
      m_elapsed = 0; m_target = interval_len(int'(v)); m_active = 1; m_done = 0;
    end else if (en && m_active) begin
      m_elapsed++;
      if (m_elapsed == m_target) begin m_done = 1; m_active = 0; end
    end
    #1;
    chk(done == m_done, (pre_done && !ld) ? "R5" : tag, int'(done), int'(m_done));
  endtask

  task automatic idle_cycles(input int n, input bit en, input string tag);
    for (int i = 0; i < n; i++) step(0, '0, en, i[0], tag);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    test = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(skip == 1'b0, "R1", int'(skip), 0);
    rst_n = 1'b1;
    idle_cycles(5, 1, "R1");

    // R4: shortest interval, exactly 63 enabled cycles
    step(1, 6'd0, 1, 0, "R2");
    idle_cycles(62, 1, "R4");
    chk(done == 1'b0, "R4", int'(done), 0);
    step(0, '0, 1, 1, "R4");
    chk(done == 1'b1, "R4", int'(done), 1);
    // R5: stays set with enable and test
    idle_cycles(200, 1, "R5");
    chk(done == 1'b1, "R5", int'(done), 1);
    // R7: skip when test high and done
    @(negedge clk); test = 1'b1; #1;
    chk(skip == 1'b1, "R7", int'(skip), 1);

    // R4: longest interval, 4032 cycles
    step(1, 6'd63, 1, 0, "R2");
    chk(done == 1'b0, "R2", int'(done), 0);
    idle_cycles(4031, 1, "R4");
    chk(done == 1'b0, "R4", int'(done), 0);
    step(0, '0, 1, 0, "R4");
    chk(done == 1'b1, "R4", int'(done), 1);

    // R3: enable low freezes the count
    step(1, 6'd1, 1, 0, "R2");
    idle_cycles(100, 1, "R3");
    idle_cycles(300, 0, "R3");
    idle_cycles(26, 1, "R3");
    chk(done == 1'b1, "R3", int'(done), 1);

    // R6: abort mid-count
    step(1, 6'd3, 1, 0, "R2");
    idle_cycles(150, 1, "R6");
    step(1, 6'd1, 1, 0, "R6");
    idle_cycles(125, 1, "R6");
    chk(done == 1'b0, "R6", int'(done), 0);
    step(0, '0, 1, 0, "R6");
    chk(done == 1'b1, "R6", int'(done), 1);

    // R8: load on the expiring edge
    step(1, 6'd0, 1, 0, "R2");
    idle_cycles(62, 1, "R8");
    step(1, 6'd0, 1, 0, "R8");
    chk(done == 1'b0, "R8", int'(done), 0);
    idle_cycles(63, 1, "R8");
    chk(done == 1'b1, "R8", int'(done), 1);

    // Random intervals with random enable duty and occasional reloads
    for (int k = 0; k < 24; k++) begin
      int duty = 30 + int'($urandom_range(0, 70));
      int n    = int'($urandom_range(0, 9));
      int len  = 63 * (n + 1) * 100 / duty + int'($urandom_range(0, 120));
      step(1, n[5:0], $urandom_range(0, 1) == 1, 0, "R2");
      for (int c = 0; c < len; c++) begin
        bit en = int'($urandom_range(1, 100)) <= duty;
        bit rl = $urandom_range(0, 999) == 0;
        step(rl, 6'($urandom_range(0, 5)), en, $urandom_range(0, 1) == 1, rl ? "R6" : "R4");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule